// File: doc/BRIEF.md
# Virtualization-Enable Instruction Checker

This unit runs the architectural screening and state updates for the instruction that switches a logical processor into hardware-virtualization operation. A one-cycle `start` pulse makes the unit take a snapshot of the processor's mode and judge it. The checks come in a strict order. Three fault outcomes are possible: undefined-opcode, general-protection and a VM exit. Two failure outcomes are possible: fail-invalid and fail-valid. If every check passes, the unit performs two dependent memory reads. The first read fetches a 64-bit structure pointer from the operand address. The second read fetches a 32-bit revision word from the address held in that pointer.

The result appears for exactly one cycle, with `done` high. It consists of a 3-bit outcome code, a six-bit arithmetic-flag result with a write enable, an error number, and a set of update strobes that the surrounding core applies to its own state. The physical-address width is a parameter in the range 36 to 52 bits.

Top module: `vxen_checker`

## Requirements
- R1: Outcome codes are OK=0, FAIL_INV=1, FAIL_VAL=2, UD=3, GP=4, EXIT=5. UD is reported ahead of every other check when any of these holds: the operand is a register, protection is off, the virtualization control bit is clear, the virtual-8086 flag is set, or long mode is active with a code segment that is not 64-bit.
- R2: Outside virtualization operation, GP is reported when any of these holds: privilege is above 0, address-20 masking is on, or the control registers are invalid. GP is also reported for three cases of `feat_ctl`: bit 0 (lock) is clear; bit 1 is clear in secure mode; bit 2 is clear outside secure mode.
- R3: Inside virtualization operation, non-root gives EXIT. Root with privilege above 0 gives GP. Root at privilege 0 gives FAIL_VAL with flags 6'b001000 (ZF only) and `err_num`=15.
- R4: A UD, GP, EXIT or FAIL_VAL outcome issues no memory read, and `done` rises in the cycle after `start`.
- R5: The first read puts `operand_addr` on `mem_addr` and holds `mem_req` and `mem_addr` steady until `mem_ack`. Only one read is outstanding at a time.
- R6: The fetched pointer gives FAIL_INV, with no second read, if any of its bits 11:0 is set or any bit at or above `PA_WIDTH` is set.
- R7: When `cap_ptr_low4g` is 1, a pointer with any bit of 63:32 set gives FAIL_INV.
- R8: The second read uses the pointer as its address. It gives FAIL_INV unless bits 30:0 of the returned word equal `rev_id` and bit 31 is 0.
- R9: Success reports OK with `flag_we`=1 and all flags clear. In the same cycle it pulses `ptr_set_ones`, `enter_virt`, `block_init`, `a20_block` and `mon_clear`.
- R10: `trace_clear` pulses on success only when `trace_present`=1 and `trace_in_virt_ok`=0.
- R11: FAIL_INV gives flags 6'b000001 (CF only; bit 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF). `flag_we` is 0 for UD, GP and EXIT.
- R12: A `start` while `busy` is ignored. The read in progress and the outcome it leads to are unchanged.
- R13: After reset the unit is idle, with `busy`, `done`, `mem_req`, `flag_we` and every strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one instruction |
| op_is_reg | input | 1 | Operand encodes a register |
| prot_en | input | 1 | Protection enabled |
| virt_ctl_en | input | 1 | Virtualization control bit |
| v86_flag | input | 1 | Virtual-8086 flag |
| long_active | input | 1 | Long mode active |
| cs_64bit | input | 1 | Code segment is 64-bit |
| cpl | input | 2 | Current privilege level |
| a20_mask | input | 1 | Address-20 masking active |
| cr_valid | input | 1 | Control register values supported |
| secure_mode | input | 1 | Secure-mode operation |
| feat_ctl | input | 3 | Feature-control bits (0 lock, 1 secure enable, 2 normal enable) |
| cap_ptr_low4g | input | 1 | Pointer restricted below 4 GiB |
| trace_present | input | 1 | Tracing supported |
| trace_in_virt_ok | input | 1 | Tracing permitted in virtualization |
| virt_active | input | 1 | Already in virtualization operation |
| virt_nonroot | input | 1 | In non-root operation |
| rev_id | input | 31 | Supported revision ID |
| operand_addr | input | 64 | Address of the memory operand |
| mem_req | output | 1 | Read request |
| mem_addr | output | 64 | Read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Unit is fetching |
| done | output | 1 | Outcome valid (one cycle) |
| outcome | output | 3 | Outcome code |
| flag_we | output | 1 | Write the flag result |
| flags | output | 6 | Flag result |
| err_num | output | 5 | Error number for FAIL_VAL |
| ptr_set_ones | output | 1 | Set current-structure pointer to all ones |
| enter_virt | output | 1 | Enter virtualization operation |
| block_init | output | 1 | Block INIT |
| a20_block | output | 1 | Block and disable address-20 masking |
| mon_clear | output | 1 | Clear address-range monitoring |
| trace_clear | output | 1 | Clear trace enable |

## Verification
The assertions take two things for granted. First, the memory side raises `mem_ack` only while `mem_req` is high, and holds it for exactly one cycle per read. Second, the mode snapshot is only meaningful in the `start` cycle. The stimulus raises acknowledges only after it has seen a request, and lowers them at the next falling edge. It changes mode inputs only alongside a `start` pulse, with one deliberate exception: a start pulse carrying a faulting snapshot is delivered during a read, to exercise the busy case.

// File: rtl/vxen_pkg.sv
package vxen_pkg;

    typedef enum logic [2:0] {
        VX_OK       = 3'd0,
        VX_FAIL_INV = 3'd1,
        VX_FAIL_VAL = 3'd2,
        VX_UD       = 3'd3,
        VX_GP       = 3'd4,
        VX_EXIT     = 3'd5
    } vx_outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_REV  = 2'd2
    } vx_state_e;

    typedef struct packed {
        logic       op_is_reg;
        logic       prot_en;
        logic       virt_ctl_en;
        logic       v86;
        logic       lma;
        logic       cs64;
        logic [1:0] cpl;
        logic       a20;
        logic       cr_ok;
        logic       secure;
        logic [2:0] feat;
        logic       in_virt;
        logic       nonroot;
    } vx_mode_s;

    localparam int FLAG_W = 6;
    localparam int ERR_W  = 5;
    localparam logic [ERR_W-1:0] ERR_IN_ROOT = 5'd15;

    // flag bit order: 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF
    function automatic logic [FLAG_W-1:0] flags_for(vx_outcome_e code);
        case (code)
            VX_FAIL_INV: return 6'b000001;
            VX_FAIL_VAL: return 6'b001000;
            default:     return 6'b000000;
        endcase
    endfunction

    function automatic logic writes_flags(vx_outcome_e code);
        return (code == VX_OK) || (code == VX_FAIL_INV) || (code == VX_FAIL_VAL);
    endfunction

endpackage

// File: rtl/vxen_gate.sv
module vxen_gate
    import vxen_pkg::*;
(
    input  vx_mode_s    mode,
    output logic        go_mem,
    output vx_outcome_e imm_code
);
    logic ud_hit;
    logic gp_outside;

    always_comb begin
        ud_hit = mode.op_is_reg | ~mode.prot_en | ~mode.virt_ctl_en | mode.v86
               | (mode.lma & ~mode.cs64);
        gp_outside = (mode.cpl != 2'd0) | mode.a20 | ~mode.cr_ok | ~mode.feat[0]
                   | (mode.secure & ~mode.feat[1])
                   | (~mode.secure & ~mode.feat[2]);
        go_mem   = 1'b0;
        imm_code = VX_UD;
        if (ud_hit) begin
            imm_code = VX_UD;
        end else if (!mode.in_virt) begin
            if (gp_outside) imm_code = VX_GP;
            else            go_mem   = 1'b1;
        end else if (mode.nonroot) begin
            imm_code = VX_EXIT;
        end else if (mode.cpl != 2'd0) begin
            imm_code = VX_GP;
        end else begin
            imm_code = VX_FAIL_VAL;
        end
    end
endmodule

// File: rtl/vxen_ptr_check.sv
module vxen_ptr_check #(
    parameter int PA_WIDTH = 40
) (
    input  logic [63:0] ptr,
    input  logic        low4g_only,
    output logic        bad
);
    localparam logic [63:0] PA_MASK = (64'd1 << PA_WIDTH) - 64'd1;

    always_comb begin
        bad = (|ptr[11:0]) | (|(ptr & ~PA_MASK)) | (low4g_only & (|ptr[63:32]));
    end
endmodule

// File: rtl/vxen_rev_check.sv
module vxen_rev_check (
    input  logic [31:0] word,
    input  logic [30:0] rev_id,
    output logic        ok
);
    always_comb begin
        ok = (word[30:0] == rev_id) && !word[31];
    end
endmodule

// File: rtl/vxen_checker.sv
module vxen_checker
    import vxen_pkg::*;
#(
    parameter int PA_WIDTH = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_is_reg,
    input  logic        prot_en,
    input  logic        virt_ctl_en,
    input  logic        v86_flag,
    input  logic        long_active,
    input  logic        cs_64bit,
    input  logic [1:0]  cpl,
    input  logic        a20_mask,
    input  logic        cr_valid,
    input  logic        secure_mode,
    input  logic [2:0]  feat_ctl,
    input  logic        cap_ptr_low4g,
    input  logic        trace_present,
    input  logic        trace_in_virt_ok,
    input  logic        virt_active,
    input  logic        virt_nonroot,
    input  logic [30:0] rev_id,
    input  logic [63:0] operand_addr,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_ack,
    input  logic [63:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [2:0]  outcome,
    output logic        flag_we,
    output logic [5:0]  flags,
    output logic [4:0]  err_num,
    output logic        ptr_set_ones,
    output logic        enter_virt,
    output logic        block_init,
    output logic        a20_block,
    output logic        mon_clear,
    output logic        trace_clear
);
    vx_mode_s    mode;
    vx_state_e   state;
    logic        go_mem;
    vx_outcome_e imm_code;
    logic        ptr_bad;
    logic        rev_ok;

    logic [63:0] op_addr_q;
    logic [63:0] ptr_q;
    logic [30:0] rev_q;
    logic        low4g_q;
    logic        trace_kill_q;

    logic        fin_valid;
    vx_outcome_e fin_code;

    assign mode = '{op_is_reg: op_is_reg, prot_en: prot_en, virt_ctl_en: virt_ctl_en,
                    v86: v86_flag, lma: long_active, cs64: cs_64bit, cpl: cpl,
                    a20: a20_mask, cr_ok: cr_valid, secure: secure_mode,
                    feat: feat_ctl, in_virt: virt_active, nonroot: virt_nonroot};

    vxen_gate u_gate (
        .mode     (mode),
        .go_mem   (go_mem),
        .imm_code (imm_code)
    );

    vxen_ptr_check #(.PA_WIDTH(PA_WIDTH)) u_ptr (
        .ptr        (mem_rdata),
        .low4g_only (low4g_q),
        .bad        (ptr_bad)
    );

    vxen_rev_check u_rev (
        .word   (mem_rdata[31:0]),
        .rev_id (rev_q),
        .ok     (rev_ok)
    );

    assign busy     = (state != ST_IDLE);
    assign mem_req  = busy;
    assign mem_addr = (state == ST_REV) ? ptr_q : op_addr_q;

    always_comb begin
        fin_valid = 1'b0;
        fin_code  = VX_OK;
        case (state)
            ST_IDLE: begin
                fin_valid = start && !go_mem;
                fin_code  = imm_code;
            end
            ST_PTR: begin
                fin_valid = mem_ack && ptr_bad;
                fin_code  = VX_FAIL_INV;
            end
            ST_REV: begin
                fin_valid = mem_ack;
                fin_code  = rev_ok ? VX_OK : VX_FAIL_INV;
            end
            default: begin
                fin_valid = 1'b0;
                fin_code  = VX_OK;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            op_addr_q    <= '0;
            ptr_q        <= '0;
            rev_q        <= '0;
            low4g_q      <= 1'b0;
            trace_kill_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start && go_mem) begin
                    state        <= ST_PTR;
                    op_addr_q    <= operand_addr;
                    rev_q        <= rev_id;
                    low4g_q      <= cap_ptr_low4g;
                    trace_kill_q <= trace_present & ~trace_in_virt_ok;
                end
                ST_PTR: if (mem_ack) begin
                    ptr_q <= mem_rdata;
                    state <= ptr_bad ? ST_IDLE : ST_REV;
                end
                ST_REV: if (mem_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done         <= 1'b0;
            outcome      <= VX_OK;
            flag_we      <= 1'b0;
            flags        <= '0;
            err_num      <= '0;
            ptr_set_ones <= 1'b0;
            enter_virt   <= 1'b0;
            block_init   <= 1'b0;
            a20_block    <= 1'b0;
            mon_clear    <= 1'b0;
            trace_clear  <= 1'b0;
        end else begin
            done         <= fin_valid;
            outcome      <= fin_code;
            flag_we      <= fin_valid && writes_flags(fin_code);
            flags        <= flags_for(fin_code);
            err_num      <= (fin_code == VX_FAIL_VAL) ? ERR_IN_ROOT : '0;
            ptr_set_ones <= fin_valid && (fin_code == VX_OK);
            enter_virt   <= fin_valid && (fin_code == VX_OK);
            block_init   <= fin_valid && (fin_code == VX_OK);
            a20_block    <= fin_valid && (fin_code == VX_OK);
            mon_clear    <= fin_valid && (fin_code == VX_OK);
            trace_clear  <= fin_valid && (fin_code == VX_OK) && trace_kill_q;
        end
    end
endmodule

// File: rtl/vxen_sva.sv
module vxen_sva
    import vxen_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [2:0]  outcome,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [63:0] mem_addr,
    input logic        flag_we,
    input logic [5:0]  flags,
    input logic [4:0]  err_num,
    input logic        ptr_set_ones,
    input logic        enter_virt,
    input logic        block_init,
    input logic        a20_block,
    input logic        mon_clear,
    input logic        trace_clear
);
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r4_no_read_on_fault: assert property (@(posedge clk) disable iff (rst)
        (done && (outcome == VX_UD || outcome == VX_GP || outcome == VX_EXIT
                  || outcome == VX_FAIL_VAL)) |-> !$past(busy));

    a_r9_success_strobes: assert property (@(posedge clk) disable iff (rst)
        enter_virt |-> (done && outcome == VX_OK && ptr_set_ones && block_init
                        && a20_block && mon_clear));

    a_r9_success_flags: assert property (@(posedge clk) disable iff (rst)
        (done && outcome == VX_OK) |-> (flag_we && flags == 6'b000000));

    a_r11_fail_inv_flags: assert property (@(posedge clk) disable iff (rst)
        (done && outcome == VX_FAIL_INV) |-> (flag_we && flags == 6'b000001));

    a_r3_fail_valid: assert property (@(posedge clk) disable iff (rst)
        (done && outcome == VX_FAIL_VAL) |-> (flag_we && flags == 6'b001000 && err_num == 5'd15));

    a_r10_trace_only_on_success: assert property (@(posedge clk) disable iff (rst)
        trace_clear |-> enter_virt);

    a_r12_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

bind vxen_checker vxen_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .outcome      (outcome),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .flag_we      (flag_we),
    .flags        (flags),
    .err_num      (err_num),
    .ptr_set_ones (ptr_set_ones),
    .enter_virt   (enter_virt),
    .block_init   (block_init),
    .a20_block    (a20_block),
    .mon_clear    (mon_clear),
    .trace_clear  (trace_clear)
);

// File: tb/vxen_checker_tb_top.sv
module vxen_checker_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        start = 0, op_is_reg = 0, prot_en = 0, virt_ctl_en = 0, v86_flag = 0;
    logic        long_active = 0, cs_64bit = 0, a20_mask = 0, cr_valid = 0, secure_mode = 0;
    logic [1:0]  cpl = 0;
    logic [2:0]  feat_ctl = 0;
    logic        cap_ptr_low4g = 0, trace_present = 0, trace_in_virt_ok = 0;
    logic        virt_active = 0, virt_nonroot = 0;
    logic [30:0] rev_id = 31'h12;
    logic [63:0] operand_addr = 64'h1000_0040;
    logic        mem_ack = 0;
    logic [63:0] mem_rdata = 0;
    logic        mem_req, busy, done, flag_we;
    logic [63:0] mem_addr;
    logic [2:0]  outcome;
    logic [5:0]  flags;
    logic [4:0]  err_num;
    logic        ptr_set_ones, enter_virt, block_init, a20_block, mon_clear, trace_clear;

    int n_chk = 0;
    int n_bad = 0;

    vxen_checker #(.PA_WIDTH(40)) dut_i (.*);

    localparam logic [2:0] C_OK = 3'd0, C_FI = 3'd1, C_FV = 3'd2, C_UD = 3'd3,
                           C_GP = 3'd4, C_EX = 3'd5;
    // mode bits MSB first: op pe vmxe vm lma csl cpl[1:0] a20 crok smx feat[2:0] inv nr
    localparam logic [15:0] BASE = 16'b0_1_1_0_1_1_00_0_1_0_101_0_0;
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {16'b1_1_1_0_1_1_00_0_1_0_101_0_0, C_UD},
        {16'b0_0_1_0_1_1_00_0_1_0_101_0_0, C_UD},
        {16'b0_1_0_0_1_1_00_0_1_0_101_0_0, C_UD},
        {16'b0_1_1_1_1_1_00_0_1_0_101_0_0, C_UD},
        {16'b0_1_1_0_1_0_00_0_1_0_101_0_0, C_UD},
        {16'b0_1_1_0_0_0_11_0_1_0_101_0_0, C_GP},
        {16'b1_1_1_0_1_1_11_0_1_0_101_0_0, C_UD},
        {16'b0_1_1_0_1_1_00_1_1_0_101_0_0, C_GP},
        {16'b0_1_1_0_1_1_00_0_0_0_101_0_0, C_GP},
        {16'b0_1_1_0_1_1_00_0_1_0_100_0_0, C_GP},
        {16'b0_1_1_0_1_1_00_0_1_1_101_0_0, C_GP},
        {16'b0_1_1_0_1_1_00_0_1_0_011_0_0, C_GP},
        {16'b0_1_1_0_1_1_11_0_1_0_101_1_1, C_EX},
        {16'b0_1_1_0_1_1_10_0_1_0_101_1_0, C_GP},
        {16'b0_1_1_0_1_1_00_0_1_0_101_1_0, C_FV},
        {16'b0_1_0_0_1_1_00_0_1_0_101_1_0, C_UD}
    };

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [15:0] m);
        {op_is_reg, prot_en, virt_ctl_en, v86_flag, long_active, cs_64bit, cpl,
         a20_mask, cr_valid, secure_mode, feat_ctl, virt_active, virt_nonroot} = m;
    endtask

    task automatic run_mem(input logic [15:0] m, input logic cap, input logic tsup,
                           input logic tok, input logic [63:0] ptr, input logic [31:0] rev,
                           input logic [2:0] exp_code, input logic two_reads,
                           input logic exp_trace, input logic poke_busy, input string tag);
        @(negedge clk);
        set_mode(m);
        cap_ptr_low4g = cap; trace_present = tsup; trace_in_virt_ok = tok;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(mem_req && mem_addr == operand_addr, {"R5 first read addr ", tag}, mem_addr, operand_addr);
        if (poke_busy) begin
            set_mode(16'b1_0_0_1_0_0_11_1_0_0_000_0_0);
            start = 1;
        end
        @(negedge clk);
        start = 0;
        set_mode(m);
        chk(mem_req && mem_addr == operand_addr && !done, {"R5 R12 hold until ack ", tag},
            {63'd0, done}, 64'd0);
        mem_ack = 1; mem_rdata = ptr;
        @(negedge clk);
        mem_ack = 0; mem_rdata = 0;
        if (!two_reads) begin
            chk(done && outcome == exp_code, {"R6 R7 pointer outcome ", tag}, {61'd0, outcome}, {61'd0, exp_code});
            chk(!mem_req, {"R6 no second read ", tag}, {63'd0, mem_req}, 64'd0);
            chk(flag_we && flags == 6'b000001, {"R11 fail-invalid flags ", tag}, {58'd0, flags}, 64'd1);
        end else begin
            chk(mem_req && mem_addr == ptr && !done, {"R8 second read addr ", tag}, mem_addr, ptr);
            mem_ack = 1; mem_rdata = {32'hDEAD_BEEF, rev};
            @(negedge clk);
            mem_ack = 0; mem_rdata = 0;
            chk(done && outcome == exp_code, {"R8 R9 outcome ", tag}, {61'd0, outcome}, {61'd0, exp_code});
            if (exp_code == C_OK) begin
                chk(flag_we && flags == 6'd0, {"R9 flags cleared ", tag}, {58'd0, flags}, 64'd0);
                chk(ptr_set_ones && enter_virt && block_init && a20_block && mon_clear,
                    {"R9 strobes ", tag},
                    {59'd0, ptr_set_ones, enter_virt, block_init, a20_block, mon_clear}, 64'h1f);
            end else begin
                chk(flags == 6'b000001 && !enter_virt, {"R11 rev fail flags ", tag}, {58'd0, flags}, 64'd1);
            end
            chk(trace_clear == exp_trace, {"R10 trace clear ", tag}, {63'd0, trace_clear}, {63'd0, exp_trace});
        end
        @(negedge clk);
        chk(!done && !busy, {"R12 single done ", tag}, {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !flag_we && !enter_virt && !trace_clear,
            "R13 reset state", {58'd0, busy, done, mem_req, flag_we, enter_virt, trace_clear}, 64'd0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done, "R13 idle after reset", {62'd0, busy, done}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_mode(VEC[i][18:3]);
            start = 1;
            @(negedge clk);
            start = 0;
            chk(done && outcome == VEC[i][2:0], $sformatf("R1 R2 R3 vector %0d outcome", i),
                {61'd0, outcome}, {61'd0, VEC[i][2:0]});
            chk(!mem_req && !busy, $sformatf("R4 vector %0d no read", i), {63'd0, mem_req}, 64'd0);
            if (VEC[i][2:0] == C_FV)
                chk(flag_we && flags == 6'b001000 && err_num == 5'd15, "R3 fail-valid flags",
                    {53'd0, err_num, flags}, {53'd0, 5'd15, 6'b001000});
            else
                chk(!flag_we && !enter_virt, $sformatf("R11 vector %0d no flag write", i),
                    {63'd0, flag_we}, 64'd0);
            @(negedge clk);
            chk(!done, $sformatf("R4 vector %0d single pulse", i), {63'd0, done}, 64'd0);
        end

        run_mem(BASE, 0, 1, 0, 64'h0000_000A_BCDE_F000, 32'h0000_0012, C_OK, 1, 1, 1, "basic+busy");
        run_mem(BASE, 0, 0, 0, 64'h0000_000A_BCDE_F008, 32'h0000_0012, C_FI, 0, 0, 0, "misaligned");
        run_mem(BASE, 0, 0, 0, 64'h0000_0100_0000_0000, 32'h0000_0012, C_FI, 0, 0, 0, "bit40");
        run_mem(BASE, 0, 1, 1, 64'h0000_0080_0000_0000, 32'h0000_0012, C_OK, 1, 0, 0, "bit39 ok");
        run_mem(BASE, 1, 0, 0, 64'h0000_0080_0000_0000, 32'h0000_0012, C_FI, 0, 0, 0, "R7 low4g");
        run_mem(BASE, 1, 0, 0, 64'h0000_0000_8000_0000, 32'h0000_0012, C_OK, 1, 0, 0, "R7 below 4g");
        run_mem(BASE, 0, 0, 0, 64'h0000_0000_0010_0000, 32'h0000_0013, C_FI, 1, 0, 0, "rev mismatch");
        run_mem(BASE, 0, 0, 0, 64'h0000_0000_0010_0000, 32'h8000_0012, C_FI, 1, 0, 0, "rev bit31");
        run_mem(16'b0_1_1_0_1_1_00_0_1_1_011_0_0, 0, 0, 0, 64'h0000_0000_0020_0000,
                32'h0000_0012, C_OK, 1, 0, 0, "R2 secure enabled");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule